// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC and decides whether a frame should be kept, looking only at its 48-bit destination address. A frame begins with a one-cycle `frame_start` pulse. The next six bytes taken with `byte_valid` are the destination address, first byte first. While the bytes arrive, the block builds the address and runs a CRC over it one byte per cycle. One cycle after the sixth byte it presents a verdict. The verdict holds until the next frame starts.

There are three kinds of match. A station match compares the address with the programmed station address. A broadcast match fires on the all-ones address. A multicast hash match uses the top CRC bits to pick one bin of a 64-bin table. Promiscuous mode accepts everything, and a separate mode bit turns off the station match. Each match kind has its own flag, and `accept` combines them.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset, and on the clock edge that samples `frame_start` high, `result_valid`, `accept`, `hit_station`, `hit_bcast` and `hit_mcast` all go to 0. Bytes offered before the first `frame_start` after reset are ignored.
- R2: After `frame_start`, the first six bytes taken with `byte_valid` are address bytes 0 to 5. `result_valid` stays 0 at the edge that takes the sixth byte. It rises at the following edge, together with the verdict. The verdict then holds unchanged until the next `frame_start`, and any further bytes are ignored.
- R3: `hit_station` is 1 when every address byte n equals `stn_addr[8n+7:8n]`. The station address comes from three 16-bit words: word k is `stn_addr[16k+15:16k]`, and its low byte is the earlier address byte.
- R4: While `dis_station` is 1 at the evaluation edge, `hit_station` is 0 whatever the address.
- R5: `hit_bcast` is 1 exactly when all six address bytes are 8'hFF.
- R6: The hash CRC works as follows. It starts at 32'hFFFF_FFFF. It takes the address bits LSB first, byte 0 first. For each bit it shifts right by one and XORs in 32'hEDB88320 when old bit 0 XOR the data bit is 1. No final inversion is applied. The bin index is CRC[31:26]. It selects `hash_table` byte index[5:3], bit index[2:0], which is `hash_table[index]`.
- R7: `hit_mcast` is 1 only when bit 0 of address byte 0 is 1, `hash_table` is non-zero, and the selected bin is 1.
- R8: While `promisc` is 1 at the evaluation edge, `accept` is 1 for every frame.
- R9: When `result_valid` is 1, `accept` equals `promisc` OR `hit_station` OR `hit_bcast` OR `hit_mcast`. When `result_valid` is 0, `accept` and all flags are 0.
- R10: A `frame_start` pulse in the middle of an address restarts capture. A byte offered in the same cycle as `frame_start` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse marking a new frame |
| byte_valid | input | 1 | `byte_data` carries a frame byte this cycle |
| byte_data | input | 8 | Frame byte |
| stn_addr | input | 48 | Station address, byte n in bits [8n+7:8n] |
| hash_table | input | 64 | Multicast hash bins, bin i in bit i |
| promisc | input | 1 | Accept every frame |
| dis_station | input | 1 | Suppress the station address match |
| result_valid | output | 1 | Verdict and flags are valid |
| accept | output | 1 | Frame is accepted |
| hit_station | output | 1 | Station address matched |
| hit_bcast | output | 1 | Broadcast address seen |
| hit_mcast | output | 1 | Multicast hash bin matched |

## Verification
The verdict is due two edges after the sixth byte is driven. The edge that takes the sixth byte only arms the evaluation, and the next edge registers the flags. The bench drives each input at a falling edge. It checks that `result_valid` is still low half a cycle after the sixth-byte edge, then checks every flag and `accept` one full cycle later. A cleared verdict is checked half a cycle after the edge that samples `frame_start`, and extra bytes sent after the verdict are checked against the held values.

// File: rtl/dst_filt_pkg.sv
package dst_filt_pkg;

    localparam int unsigned CRC_W = 32;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB8_8320;
    localparam logic [CRC_W-1:0] CRC_SEED      = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_CAPTURE,
        PH_EVAL,
        PH_HOLD
    } dst_phase_e;

endpackage

// File: rtl/dst_crc_step.sv
// One byte of reflected CRC, unrolled over the data bits (LSB first).
module dst_crc_step
    import dst_filt_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter logic [CRC_W-1:0] POLY = CRC_POLY_REFL
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);

    logic [CRC_W-1:0] chain [0:DATA_W];

    assign chain[0] = crc_in;

    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        logic fb;
        assign fb = chain[g][0] ^ data_in[g];
        assign chain[g+1] = (chain[g] >> 1) ^ (fb ? POLY : '0);
    end

    assign crc_out = chain[DATA_W];

endmodule

// File: rtl/dst_match_eval.sv
// Combinational match decisions on a fully captured address.
module dst_match_eval #(
    parameter int unsigned ADDR_BYTES = 6,
    parameter int unsigned HASH_BITS  = 6,
    localparam int unsigned ADDR_W    = ADDR_BYTES * 8,
    localparam int unsigned TABLE_W   = 1 << HASH_BITS
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [ADDR_W-1:0]    stn_addr,
    input  logic [TABLE_W-1:0]   hash_table,
    input  logic [HASH_BITS-1:0] hash_idx,
    input  logic                 promisc,
    input  logic                 dis_station,
    output logic                 m_station,
    output logic                 m_bcast,
    output logic                 m_mcast,
    output logic                 m_accept
);

    logic group_bit;
    logic table_live;

    assign group_bit  = addr[0];
    assign table_live = |hash_table;

    always_comb begin
        m_station = !dis_station && (addr == stn_addr);
        m_bcast   = &addr;
        m_mcast   = group_bit && table_live && hash_table[hash_idx];
        m_accept  = promisc || m_station || m_bcast || m_mcast;
    end

endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
    import dst_filt_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = 6,
    parameter int unsigned HASH_BITS  = 6,
    localparam int unsigned ADDR_W    = ADDR_BYTES * 8,
    localparam int unsigned TABLE_W   = 1 << HASH_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               byte_valid,
    input  logic [7:0]         byte_data,
    input  logic [ADDR_W-1:0]  stn_addr,
    input  logic [TABLE_W-1:0] hash_table,
    input  logic               promisc,
    input  logic               dis_station,
    output logic               result_valid,
    output logic               accept,
    output logic               hit_station,
    output logic               hit_bcast,
    output logic               hit_mcast
);

    localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(ADDR_BYTES - 1);

    typedef struct packed {
        dst_phase_e        phase;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [CRC_W-1:0]  crc;
        logic              valid;
        logic              acc;
        logic              st;
        logic              bc;
        logic              mc;
    } filt_state_t;

    filt_state_t s_q, s_d;

    logic [CRC_W-1:0] crc_next;
    logic m_station, m_bcast, m_mcast, m_accept;

    dst_crc_step #(
        .DATA_W (8),
        .POLY   (CRC_POLY_REFL)
    ) u_crc (
        .crc_in  (s_q.crc),
        .data_in (byte_data),
        .crc_out (crc_next)
    );

    dst_match_eval #(
        .ADDR_BYTES (ADDR_BYTES),
        .HASH_BITS  (HASH_BITS)
    ) u_match (
        .addr        (s_q.addr),
        .stn_addr    (stn_addr),
        .hash_table  (hash_table),
        .hash_idx    (s_q.crc[CRC_W-1 -: HASH_BITS]),
        .promisc     (promisc),
        .dis_station (dis_station),
        .m_station   (m_station),
        .m_bcast     (m_bcast),
        .m_mcast     (m_mcast),
        .m_accept    (m_accept)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            PH_CAPTURE: begin
                if (byte_valid) begin
                    for (int i = 0; i < ADDR_BYTES; i++) begin
                        if (s_q.cnt == CNT_W'(i)) begin
                            s_d.addr[i*8 +: 8] = byte_data;
                        end
                    end
                    s_d.crc = crc_next;
                    s_d.cnt = s_q.cnt + 1'b1;
                    if (s_q.cnt == LAST_BYTE) begin
                        s_d.phase = PH_EVAL;
                    end
                end
            end
            PH_EVAL: begin
                s_d.valid = 1'b1;
                s_d.acc   = m_accept;
                s_d.st    = m_station;
                s_d.bc    = m_bcast;
                s_d.mc    = m_mcast;
                s_d.phase = PH_HOLD;
            end
            default: ;
        endcase

        if (frame_start) begin
            s_d.phase = PH_CAPTURE;
            s_d.cnt   = '0;
            s_d.addr  = '0;
            s_d.crc   = CRC_SEED;
            s_d.valid = 1'b0;
            s_d.acc   = 1'b0;
            s_d.st    = 1'b0;
            s_d.bc    = 1'b0;
            s_d.mc    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.phase <= PH_IDLE;
            s_q.cnt   <= '0;
            s_q.addr  <= '0;
            s_q.crc   <= CRC_SEED;
            s_q.valid <= 1'b0;
            s_q.acc   <= 1'b0;
            s_q.st    <= 1'b0;
            s_q.bc    <= 1'b0;
            s_q.mc    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign result_valid = s_q.valid;
    assign accept       = s_q.acc;
    assign hit_station  = s_q.st;
    assign hit_bcast    = s_q.bc;
    assign hit_mcast    = s_q.mc;

endmodule

// File: rtl/dst_filt_checker.sv
module dst_filt_checker #(
    parameter int unsigned ADDR_BYTES = 6,
    parameter int unsigned TABLE_W    = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frame_start,
    input logic               byte_valid,
    input logic [TABLE_W-1:0] hash_table,
    input logic               promisc,
    input logic               dis_station,
    input logic               result_valid,
    input logic               accept,
    input logic               hit_station,
    input logic               hit_bcast,
    input logic               hit_mcast
);

    logic [7:0] ck_cnt;
    logic       ck_live;
    logic       six_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_cnt  <= '0;
            ck_live <= 1'b0;
            six_q   <= 1'b0;
        end else begin
            six_q <= 1'b0;
            if (frame_start) begin
                ck_cnt  <= '0;
                ck_live <= 1'b1;
            end else if (ck_live && byte_valid && ck_cnt < 8'(ADDR_BYTES)) begin
                ck_cnt <= ck_cnt + 8'd1;
                if (ck_cnt == 8'(ADDR_BYTES - 1)) begin
                    six_q <= 1'b1;
                end
            end
        end
    end

    a_r1_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !result_valid && !accept);

    a_r2_not_early: assert property (@(posedge clk) disable iff (!rst_n)
        six_q |-> !result_valid);

    a_r2_due_next: assert property (@(posedge clk) disable iff (!rst_n)
        six_q && !frame_start |=> result_valid);

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid && !frame_start |=> result_valid && $stable(accept)
            && $stable(hit_station) && $stable(hit_bcast) && $stable(hit_mcast));

    a_r4_station_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(result_valid) && $past(dis_station) |-> !hit_station);

    a_r7_empty_table: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(result_valid) && ($past(hash_table) == '0) |-> !hit_mcast);

    a_r8_promisc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(result_valid) && $past(promisc) |-> accept);

    a_r9_flag_implies_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_station || hit_bcast || hit_mcast) |-> accept && result_valid);

    a_r9_quiet_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> !accept && !hit_station && !hit_bcast && !hit_mcast);

endmodule

bind dst_addr_filter dst_filt_checker #(
    .ADDR_BYTES (ADDR_BYTES),
    .TABLE_W    (TABLE_W)
) u_chk (.*);

// File: tb/dst_addr_filter_bench.sv
module dst_addr_filter_bench;

    localparam logic [31:0] POLY = 32'hEDB8_8320;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic [47:0] stn_addr = '0;
    logic [63:0] hash_table = '0;
    logic        promisc = 1'b0;
    logic        dis_station = 1'b0;
    logic        result_valid, accept, hit_station, hit_bcast, hit_mcast;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dst_addr_filter u_dst_addr_filter (
        .clk, .rst_n, .frame_start, .byte_valid, .byte_data, .stn_addr,
        .hash_table, .promisc, .dis_station, .result_valid, .accept,
        .hit_station, .hit_bcast, .hit_mcast
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_of(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int k = 0; k < 48; k++) begin
            logic fb;
            fb = c[0] ^ a[k];
            c = c >> 1;
            if (fb) c = c ^ POLY;
        end
        return c;
    endfunction

    function automatic logic [5:0] idx_of(input logic [47:0] a);
        logic [31:0] c = crc_of(a);
        return c[31:26];
    endfunction

    // Sends frame_start and six address bytes, then checks timing and verdict.
    task automatic run_frame(input logic [47:0] a, input bit collide);
        logic st, bc, mc, acc;
        frame_start = 1'b1;
        byte_valid  = collide;
        byte_data   = 8'hA5;
        @(negedge clk);
        frame_start = 1'b0;
        for (int i = 0; i < 6; i++) begin
            byte_valid = 1'b1;
            byte_data  = a[8*i +: 8];
            @(negedge clk);
        end
        byte_valid = 1'b0;
        chk("R2", "valid low at sixth-byte edge", 64'(result_valid), 64'd0);
        @(negedge clk);
        st  = !dis_station && (a == stn_addr);
        bc  = (a == '1);
        mc  = a[0] && (hash_table != '0) && hash_table[idx_of(a)];
        acc = promisc || st || bc || mc;
        chk("R2", "valid one cycle later", 64'(result_valid), 64'd1);
        chk(dis_station ? "R4" : "R3", "station flag", 64'(hit_station), 64'(st));
        chk("R5", "broadcast flag", 64'(hit_bcast), 64'(bc));
        chk(hash_table == '0 ? "R7" : "R6", "hash flag", 64'(hit_mcast), 64'(mc));
        chk(promisc ? "R8" : "R9", "accept", 64'(accept), 64'(acc));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [47:0] a;
        logic [5:0]  ix;
        logic        hold_acc, hold_st;
        void'($urandom(32'd20240611));

        stn_addr = 48'h5634_1200_BE02;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "valid after reset", 64'(result_valid), 64'd0);
        chk("R1", "accept after reset", 64'(accept), 64'd0);

        // Bytes before any frame start are ignored.
        for (int i = 0; i < 8; i++) begin
            byte_valid = 1'b1;
            byte_data  = 8'hFF;
            @(negedge clk);
        end
        byte_valid = 1'b0;
        @(negedge clk);
        chk("R1", "no verdict without frame start", 64'(result_valid), 64'd0);

        // Station match, word layout: low byte of word 0 is address byte 0.
        run_frame(stn_addr, 1'b0);
        hold_acc = accept;
        hold_st  = hit_station;
        // Extra bytes after the address are ignored.
        for (int i = 0; i < 3; i++) begin
            byte_valid = 1'b1;
            byte_data  = 8'(i + 8'h31);
            @(negedge clk);
        end
        byte_valid = 1'b0;
        @(negedge clk);
        chk("R2", "accept held after extra bytes", 64'(accept), 64'(hold_acc));
        chk("R2", "station held after extra bytes", 64'(hit_station), 64'(hold_st));

        // Frame start clears the verdict.
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        chk("R1", "valid cleared by frame start", 64'(result_valid), 64'd0);
        chk("R1", "station cleared by frame start", 64'(hit_station), 64'd0);

        // Station match disabled.
        dis_station = 1'b1;
        run_frame(stn_addr, 1'b0);
        chk("R4", "station suppressed", 64'(hit_station), 64'd0);
        dis_station = 1'b0;

        // Broadcast with empty table.
        run_frame('1, 1'b0);
        chk("R5", "broadcast hit", 64'(hit_bcast), 64'd1);

        // Hash bin selection: only the computed bin set.
        a  = 48'h0000_5E00_0301;
        ix = idx_of(a);
        hash_table = 64'd1 << ix;
        run_frame(a, 1'b0);
        chk("R6", "single selected bin hits", 64'(hit_mcast), 64'd1);
        hash_table = ~(64'd1 << ix);
        run_frame(a, 1'b0);
        chk("R6", "all other bins miss", 64'(hit_mcast), 64'd0);
        // Group bit clear blocks the hash even with a full table.
        hash_table = '1;
        run_frame(a & ~48'd1, 1'b0);
        chk("R7", "individual address no hash", 64'(hit_mcast), 64'd0);
        hash_table = '0;
        run_frame(a, 1'b0);
        chk("R7", "empty table no hash", 64'(hit_mcast), 64'd0);

        // Promiscuous accepts a non-matching unicast.
        promisc = 1'b1;
        run_frame(48'h1122_3344_5500, 1'b0);
        chk("R8", "promiscuous accept", 64'(accept), 64'd1);
        promisc = 1'b0;

        // Abort mid-address, then restart with a colliding byte.
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            byte_valid = 1'b1;
            byte_data  = 8'hEE;
            @(negedge clk);
        end
        byte_valid = 1'b0;
        run_frame(stn_addr, 1'b1);
        chk("R10", "restart captures clean address", 64'(hit_station), 64'd1);

        // Random frames mixed over address kinds and modes.
        for (int n = 0; n < 60; n++) begin
            int kind;
            kind = int'($urandom_range(0, 3));
            a = {$urandom(), $urandom()};
            if (kind == 0) a = stn_addr;
            if (kind == 1) a = '1;
            if (kind == 2) a[0] = 1'b1;
            hash_table  = ($urandom_range(0, 3) == 0) ? 64'd0 : {$urandom(), $urandom()};
            promisc     = ($urandom_range(0, 7) == 0);
            dis_station = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 4) == 0) stn_addr = {$urandom(), $urandom()};
            run_frame(a, ($urandom_range(0, 5) == 0));
            repeat ($urandom_range(0, 2)) @(negedge clk);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule